// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block steers data between a 32-bit register file and a 32-bit external data bus for byte and word transfers. It supports both little endian and big endian byte order, selected per access. On a store it forms the word to drive onto the bus and the four byte-lane write strobes. On a load it turns the word read from the bus into the value written back to the destination register.

Misaligned word loads are neither faulted nor split. The fetched word is rotated by the byte offset, so a later shift instruction can pull a halfword out of the result. A byte store drives the source byte on every lane, and the lane strobes tell the memory which lane to write. An optional output register, chosen by the `REG_OUT` parameter (default 1), adds one cycle of latency. Address generation, bus handshaking, halfword accesses and sign extension belong to other blocks.

Top module: `lsa_align_unit`

## Requirements
- R1: For a word store (`is_store_i`=1, `is_byte_i`=0), `bus_wr_o` equals `st_reg_i` unchanged for every value of `addr_lo_i`. Register bit n drives bus bit n.
- R2: For a byte store (`is_store_i`=1, `is_byte_i`=1), `st_reg_i[7:0]` appears on all four byte lanes of `bus_wr_o`. Lane k is bits 8k+7:8k.
- R3: For a byte load (`is_store_i`=0, `is_byte_i`=1), the selected lane is `addr_lo_i` in little endian mode (`big_end_i`=0). In big endian mode (`big_end_i`=1) it is 3 minus `addr_lo_i`, so offset 0 takes bits 31:24. The selected lane lands in `reg_wr_o[7:0]`.
- R4: For a byte load, `reg_wr_o[31:8]` is zero.
- R5: For a word load (`is_store_i`=0, `is_byte_i`=0), `reg_wr_o` equals `bus_rd_i` rotated right by 8×`addr_lo_i` in both endian modes. Consequences:
  - In big endian mode, offsets 0 and 2 place the addressed byte in bits 31:24, and offsets 1 and 3 place it in bits 15:8.
  - In little endian mode, the addressed byte lands in bits 7:0.
- R6: `lane_en_o` bit k strobes lane k. A word store gives 4'b1111. A byte store gives exactly one bit set: bit `addr_lo_i` in little endian mode, or bit 3−`addr_lo_i` in big endian mode.
- R7: During a load, `lane_en_o` and `bus_wr_o` are zero. During a store, `reg_wr_o` is zero.
- R8: With `REG_OUT`=1, each output reflects the inputs sampled at the previous rising clock edge. With `REG_OUT`=0, outputs follow the inputs in the same cycle. While `rst_ni` is low, the registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| is_store_i | input | 1 | 1 = store, 0 = load |
| is_byte_i | input | 1 | 1 = byte access, 0 = word access |
| addr_lo_i | input | 2 | Byte offset within the word |
| big_end_i | input | 1 | 1 = big endian, 0 = little endian |
| st_reg_i | input | 32 | Register value being stored |
| bus_rd_i | input | 32 | Word read from the data bus |
| bus_wr_o | output | 32 | Word driven onto the data bus |
| reg_wr_o | output | 32 | Value for the destination register |
| lane_en_o | output | 4 | Byte-lane write strobes |

## Verification
Store steering and load steering share the output register. A store's bus word and strobes leave that register in the same cycle that the next access, often a load, is being rotated in front of it. The bench alternates stores and loads on consecutive cycles. Throughout, both data inputs carry distinct non-zero patterns. A scoreboard pairs each queued expectation with the output one cycle later. This pairing judges two things: whether any field of a store leaks into the following load's register value, and whether a load clears the strobes that the preceding store raised.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic {
    END_LITTLE = 1'b0,
    END_BIG    = 1'b1
  } endian_e;

  typedef enum logic {
    SZ_WORD = 1'b0,
    SZ_BYTE = 1'b1
  } size_e;

  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } dir_e;

endpackage

// File: rtl/lsa_lane_decode.sv
module lsa_lane_decode #(
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [OFS_W-1:0] offset_i,
  input  logic             big_end_i,
  output logic [OFS_W-1:0] lane_idx_o,
  output logic [LANES-1:0] lane_oh_o
);
  import lsa_pkg::*;

  function automatic logic [OFS_W-1:0] pick_lane(input logic [OFS_W-1:0] ofs,
                                                  input endian_e e);
    if (e == END_BIG) return OFS_W'(LANES - 1) - ofs;
    return ofs;
  endfunction

  assign lane_idx_o = pick_lane(offset_i, endian_e'(big_end_i));

  for (genvar k = 0; k < LANES; k++) begin : g_oh
    assign lane_oh_o[k] = (lane_idx_o == OFS_W'(k));
  end

endmodule

// File: rtl/lsa_store_path.sv
module lsa_store_path #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W
) (
  input  logic              is_store_i,
  input  logic              is_byte_i,
  input  logic [LANES-1:0]  lane_oh_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] bus_o,
  output logic [LANES-1:0]  stb_o
);
  import lsa_pkg::*;

  logic [DATA_W-1:0] repl_w;

  for (genvar k = 0; k < LANES; k++) begin : g_repl
    assign repl_w[k*BYTE_W +: BYTE_W] = src_i[BYTE_W-1:0];
  end

  always_comb begin
    bus_o = '0;
    stb_o = '0;
    if (dir_e'(is_store_i) == DIR_STORE) begin
      if (size_e'(is_byte_i) == SZ_BYTE) begin
        bus_o = repl_w;
        stb_o = lane_oh_i;
      end else begin
        bus_o = src_i;
        stb_o = '1;
      end
    end
  end

endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              is_store_i,
  input  logic              is_byte_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [OFS_W-1:0]  lane_idx_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] reg_o
);
  import lsa_pkg::*;

  function automatic logic [DATA_W-1:0] rot_bytes(input logic [DATA_W-1:0] w,
                                                   input logic [OFS_W-1:0] ofs);
    logic [2*DATA_W-1:0] dbl;
    dbl = {w, w} >> (int'(ofs) * BYTE_W);
    return dbl[DATA_W-1:0];
  endfunction

  logic [BYTE_W-1:0] lane_a [LANES];
  logic [BYTE_W-1:0] sel_byte_w;
  logic [DATA_W-1:0] rot_w;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_a[k] = bus_i[k*BYTE_W +: BYTE_W];
  end

  assign sel_byte_w = lane_a[lane_idx_i];
  assign rot_w      = rot_bytes(bus_i, offset_i);

  always_comb begin
    reg_o = '0;
    if (dir_e'(is_store_i) == DIR_LOAD) begin
      if (size_e'(is_byte_i) == SZ_BYTE) reg_o = {{(DATA_W-BYTE_W){1'b0}}, sel_byte_w};
      else                               reg_o = rot_w;
    end
  end

endmodule

// File: rtl/lsa_out_stage.sv
module lsa_out_stage #(
  parameter int DATA_W  = 32,
  parameter int LANES   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] bus_d,
  input  logic [DATA_W-1:0] reg_d,
  input  logic [LANES-1:0]  stb_d,
  output logic [DATA_W-1:0] bus_q,
  output logic [DATA_W-1:0] reg_q,
  output logic [LANES-1:0]  stb_q
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bus_q <= '0;
        reg_q <= '0;
        stb_q <= '0;
      end else begin
        bus_q <= bus_d;
        reg_q <= reg_d;
        stb_q <= stb_d;
      end
    end
  end else begin : g_comb
    logic unused_w;
    assign unused_w = clk_i ^ rst_ni;
    assign bus_q = bus_d;
    assign reg_q = reg_d;
    assign stb_q = stb_d;
  end

endmodule

// File: rtl/lsa_align_unit.sv
module lsa_align_unit #(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              is_store_i,
  input  logic              is_byte_i,
  input  logic [OFS_W-1:0]  addr_lo_i,
  input  logic              big_end_i,
  input  logic [DATA_W-1:0] st_reg_i,
  input  logic [DATA_W-1:0] bus_rd_i,
  output logic [DATA_W-1:0] bus_wr_o,
  output logic [DATA_W-1:0] reg_wr_o,
  output logic [LANES-1:0]  lane_en_o
);

  logic [OFS_W-1:0]  lane_idx_w;
  logic [LANES-1:0]  lane_oh_w;
  logic [DATA_W-1:0] st_bus_w;
  logic [LANES-1:0]  st_stb_w;
  logic [DATA_W-1:0] ld_reg_w;

  lsa_lane_decode #(.LANES(LANES)) u_dec (
    .offset_i  (addr_lo_i),
    .big_end_i (big_end_i),
    .lane_idx_o(lane_idx_w),
    .lane_oh_o (lane_oh_w)
  );

  lsa_store_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_st (
    .is_store_i(is_store_i),
    .is_byte_i (is_byte_i),
    .lane_oh_i (lane_oh_w),
    .src_i     (st_reg_i),
    .bus_o     (st_bus_w),
    .stb_o     (st_stb_w)
  );

  lsa_load_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ld (
    .is_store_i(is_store_i),
    .is_byte_i (is_byte_i),
    .offset_i  (addr_lo_i),
    .lane_idx_i(lane_idx_w),
    .bus_i     (bus_rd_i),
    .reg_o     (ld_reg_w)
  );

  lsa_out_stage #(.DATA_W(DATA_W), .LANES(LANES), .REG_OUT(REG_OUT)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bus_d (st_bus_w),
    .reg_d (ld_reg_w),
    .stb_d (st_stb_w),
    .bus_q (bus_wr_o),
    .reg_q (reg_wr_o),
    .stb_q (lane_en_o)
  );

endmodule

// File: rtl/lsa_align_checker.sv
module lsa_align_checker #(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              is_store_i,
  input logic              is_byte_i,
  input logic [OFS_W-1:0]  addr_lo_i,
  input logic [DATA_W-1:0] st_reg_i,
  input logic [LANES-1:0]  lane_oh_w,
  input logic [DATA_W-1:0] st_bus_w,
  input logic [LANES-1:0]  st_stb_w,
  input logic [DATA_W-1:0] ld_reg_w,
  input logic [DATA_W-1:0] bus_wr_o,
  input logic [DATA_W-1:0] reg_wr_o,
  input logic [LANES-1:0]  lane_en_o
);

  logic primed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  logic repl_ok_w;
  always_comb begin
    repl_ok_w = 1'b1;
    for (int k = 0; k < LANES; k++)
      if (st_bus_w[k*BYTE_W +: BYTE_W] != st_reg_i[BYTE_W-1:0]) repl_ok_w = 1'b0;
  end

  logic [OFS_W-1:0] unused_ofs_w;
  assign unused_ofs_w = addr_lo_i;

  assert_word_store_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_store_i && !is_byte_i) |-> (st_bus_w == st_reg_i));

  assert_byte_store_repl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_store_i && is_byte_i) |-> repl_ok_w);

  assert_byte_load_zext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_store_i && is_byte_i) |-> (ld_reg_w[DATA_W-1:BYTE_W] == '0));

  assert_byte_store_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_store_i && is_byte_i) |-> ($countones(st_stb_w) == 1 && st_stb_w == lane_oh_w));

  assert_word_store_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_store_i && !is_byte_i) |-> (&st_stb_w));

  assert_load_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_store_i |-> (st_stb_w == '0 && st_bus_w == '0));

  assert_store_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_store_i |-> (ld_reg_w == '0));

  if (REG_OUT) begin : g_lat
    assert_out_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed_q |-> (reg_wr_o == $past(ld_reg_w) && bus_wr_o == $past(st_bus_w)
                    && lane_en_o == $past(st_stb_w)));
  end else begin : g_nolat
    assert_out_direct_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed_q |-> (reg_wr_o == ld_reg_w && bus_wr_o == st_bus_w && lane_en_o == st_stb_w));
  end

endmodule

bind lsa_align_unit lsa_align_checker #(
  .DATA_W (DATA_W),
  .BYTE_W (BYTE_W),
  .REG_OUT(REG_OUT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .is_store_i(is_store_i),
  .is_byte_i (is_byte_i),
  .addr_lo_i (addr_lo_i),
  .st_reg_i  (st_reg_i),
  .lane_oh_w (lane_oh_w),
  .st_bus_w  (st_bus_w),
  .st_stb_w  (st_stb_w),
  .ld_reg_w  (ld_reg_w),
  .bus_wr_o  (bus_wr_o),
  .reg_wr_o  (reg_wr_o),
  .lane_en_o (lane_en_o)
);

// File: tb/test_lsa_align_unit.sv
`timescale 1ns/1ps
module test_lsa_align_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_store = 1'b0, is_byte = 1'b0, big_end = 1'b0;
  logic [1:0]  addr_lo = '0;
  logic [31:0] st_reg = '0, bus_rd = '0;
  logic [31:0] bus_wr, reg_wr;
  logic [3:0]  lane_en;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] bus;
    logic [31:0] rg;
    logic [3:0]  stb;
    string       tag_d;
    string       tag_r;
    string       tag_s;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  lsa_align_unit i_lsa_align_unit (
    .clk_i(clk), .rst_ni(rst_n), .is_store_i(is_store), .is_byte_i(is_byte),
    .addr_lo_i(addr_lo), .big_end_i(big_end), .st_reg_i(st_reg), .bus_rd_i(bus_rd),
    .bus_wr_o(bus_wr), .reg_wr_o(reg_wr), .lane_en_o(lane_en)
  );

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Expected model built byte by byte from the requirements.
  function automatic exp_t model(bit st, bit by, bit be, logic [1:0] ofs,
                                 logic [31:0] src, logic [31:0] rd);
    exp_t e;
    logic [7:0] b [4];
    int lane;
    for (int i = 0; i < 4; i++) b[i] = rd[8*i +: 8];
    lane = be ? 3 - int'(ofs) : int'(ofs);
    e.bus = '0; e.rg = '0; e.stb = '0;
    if (st) begin
      if (by) begin
        for (int i = 0; i < 4; i++) e.bus[8*i +: 8] = src[7:0];  // R2
        e.stb[lane] = 1'b1;                                       // R6
        e.tag_d = "R2"; e.tag_s = "R6";
      end else begin
        e.bus = src; e.stb = 4'hF;                                // R1, R6
        e.tag_d = "R1"; e.tag_s = "R6";
      end
      e.tag_r = "R7";
    end else begin
      if (by) begin
        e.rg[7:0] = b[lane];                                      // R3, R4
        e.tag_r = "R3/R4";
      end else begin
        for (int i = 0; i < 4; i++) e.rg[8*i +: 8] = b[(i + int'(ofs)) % 4]; // R5
        e.tag_r = "R5";
      end
      e.tag_d = "R7"; e.tag_s = "R7";
    end
    return e;
  endfunction

  task automatic drive(bit st, bit by, bit be, logic [1:0] ofs,
                       logic [31:0] src, logic [31:0] rd);
    @(negedge clk);
    is_store = st; is_byte = by; big_end = be; addr_lo = ofs;
    st_reg = src; bus_rd = rd;
    sbq.push_back(model(st, by, be, ofs, src, rd));
  endtask

  // Monitor: output register presents the item one edge after it is driven (R8).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check32({e.tag_d, " bus_wr R8"}, bus_wr, e.bus);
        check32({e.tag_r, " reg_wr R8"}, reg_wr, e.rg);
        check32({e.tag_s, " lane_en R8"}, {28'h0, lane_en}, {28'h0, e.stb});
      end
    end
  end

  initial begin
    #50000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hA1B2C3D4; pats[1] = 32'h11223344;
    pats[2] = 32'hFF00807F; pats[3] = 32'h0F1E2D3C;
    st_reg = 32'hDEADBEEF; bus_rd = 32'hCAFEF00D; is_store = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R8: outputs held at zero during reset
    check32("R8 reset bus_wr", bus_wr, '0);
    check32("R8 reset reg_wr", reg_wr, '0);
    check32("R8 reset lane_en", {28'h0, lane_en}, '0);
    @(negedge clk);
    is_store = 1'b0;
    rst_n = 1'b1;
    // Exhaustive sweep over direction, size, endianness, offset.
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 16; m++)
        for (int o = 0; o < 4; o++)
          drive(m[0], m[1], m[2], 2'(o), pats[p], ~pats[(p+1)%4]);
    // Store/load alternation every cycle (R7 leakage between neighbours).
    for (int o = 0; o < 4; o++)
      for (int i = 0; i < 6; i++)
        drive(i[0], i[1], o[0], 2'(o + i), pats[i%4] ^ 32'h5A5A5A5A, pats[(i+2)%4]);
    // Big endian halfword positions on word loads (R5).
    drive(0, 0, 1, 2'd0, '0, 32'h12345678);
    drive(0, 0, 1, 2'd2, '0, 32'h12345678);
    drive(0, 0, 1, 2'd1, '0, 32'h12345678);
    drive(0, 0, 0, 2'd3, '0, 32'h12345678);
    @(negedge clk);
    is_store = 1'b0; is_byte = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (sbq.size() != 0) begin
      bad++;
      $display("FAIL R8 queue actual=%0d expected=0", sbq.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule